// File: doc/BRIEF.md
# Channel Activity Cycle Counters

This block keeps four 32-bit counters that measure how a radio channel is used. The first counts every clock cycle. The second counts the cycles in which the receiver reports the medium as busy. The third counts the cycles spent receiving a frame, and the fourth counts the cycles spent transmitting one. The three activity inputs are single-bit levels that are sampled on each clock.

A control register holds one freeze bit. While it is set, all four counters hold their values together, so software can take a snapshot in which the counts agree with each other. A typical pass sets freeze, reads the four counters, writes zero to each of them and then clears freeze. Because every counter stops on the same edge, no counts are lost and none are split between counters. Software can also write any value to a counter. Idle listen time is the total minus the receive-frame and transmit-frame counts.

Top module: `chan_activity_counters`

## Requirements
- R1: After reset all four counters read zero and the freeze bit reads zero.
- R2: While freeze is clear and the counter is not written, the total-cycle counter (address 1) increases by one on every clock.
- R3: While freeze is clear and the counter is not written, the busy counter (address 2), the receive-frame counter (address 3) and the transmit-frame counter (address 4) each increase by one only in cycles where their input (busy_i, rx_i, tx_i in that order) is high. Otherwise they hold.
- R4: While the freeze bit is set, none of the four counters changes unless it is written. The freeze bit takes effect from the cycle after the control write. Clearing the bit resumes counting.
- R5: A write to a counter address loads reg_wdata into that counter on the next edge. Writing zero clears it. A write takes priority over an increment in the same cycle.
- R6: The counters wrap from 2^32-1 to 0 and never saturate.
- R7: The control register is at address 0. A write sets freeze from reg_wdata bit 0. A read returns freeze in bit 0 and zero in all other bits.
- R8: Reads from addresses 5 to 7 return zero, and writes to those addresses change no counter and do not change the freeze bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Medium-busy level |
| rx_i | input | 1 | Receiving-frame level |
| tx_i | input | 1 | Transmitting-frame level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |

## Verification
The assertions check four things on every cycle: each counter steps by exactly one or holds according to its input, a frozen counter stays stable, a write lands on the next edge, and the control and unmapped read values stay correct. The bench scenarios cover the rest. These include the wrap from all-ones to zero, the one-cycle lag of the freeze bit, the full freeze-read-clear-resume pass with counts consistent across the counters, and long random runs in which the four counters match an independent model.

// File: rtl/chact_pkg.sv
package chact_pkg;
   localparam int unsigned NUM_CNT = 4;
   typedef enum logic [2:0] {
      A_CTRL   = 3'd0,
      A_TOTAL  = 3'd1,
      A_BUSY   = 3'd2,
      A_RXFRM  = 3'd3,
      A_TXFRM  = 3'd4
   } chact_addr_e;
endpackage

// File: rtl/chact_counter.sv
module chact_counter #(
   parameter int unsigned W      = 32,
   parameter bit          ALWAYS = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         freeze,
   input  logic         inc,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] ONE = W'(1);

   initial begin
      if (W < 1) $error("chact_counter: W must be at least 1");
   end

   logic step;
   generate
      if (ALWAYS) begin : g_free
         assign step = ~freeze;
      end else begin : g_gated
         assign step = ~freeze & inc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (ld)    cnt <= ld_val;
      else if (step)  cnt <= cnt + ONE;
   end

   // R2/R3/R6: unfrozen, unwritten, active -> exactly one more (mod 2^W)
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && !ld && (inc || ALWAYS)) |=> (cnt == $past(cnt) + ONE));
   // R3: inactive input holds the count
   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !inc && !ALWAYS) |=> $stable(cnt));
   // R4: frozen counter holds
   p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !ld) |=> $stable(cnt));
   // R5: write lands on next edge, over any increment
   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/chact_regs.sv
module chact_regs #(
   parameter int unsigned W      = 32,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned N      = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [W-1:0]        wdata,
   input  logic [N*W-1:0]      cnt_flat,
   output logic [N-1:0]        ld,
   output logic                freeze,
   output logic [W-1:0]        rdata
);
   localparam int unsigned NREG = N + 1;

   initial begin
      if ((1 << ADDR_W) < NREG) $error("chact_regs: ADDR_W too small");
   end

   wire ctrl_sel = (addr == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              freeze <= 1'b0;
      else if (wr && ctrl_sel) freeze <= wdata[0];
   end

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_dec
         assign ld[gi] = wr && (addr == ADDR_W'(gi + 1));
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (ctrl_sel) rdata[0] = freeze;
      for (int i = 0; i < N; i++) begin
         if (addr == ADDR_W'(i + 1)) rdata = cnt_flat[i*W +: W];
      end
   end

   // R7: control reads freeze in bit 0, zeros elsewhere
   p_ctrl_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_sel |-> (rdata == W'(freeze)));
   // R7: control write updates freeze next cycle
   p_ctrl_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && ctrl_sel) |=> (freeze == $past(wdata[0])));
   // R8: unmapped addresses read zero and leave freeze alone
   p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(addr) >= NREG) |-> (rdata == '0));
   p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(addr) >= NREG) |-> (ld == '0));
endmodule

// File: rtl/chan_activity_counters.sv
module chan_activity_counters #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              rx_i,
   input  logic              tx_i,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata
);
   import chact_pkg::*;
   localparam int unsigned N = NUM_CNT;

   logic [N-1:0]       ld;
   logic [N-1:0]       inc;
   logic               freeze;
   logic [N*CNT_W-1:0] cnt_flat;

   assign inc = {tx_i, rx_i, busy_i, 1'b1};

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_cnt
         chact_counter #(.W(CNT_W), .ALWAYS(gi == 0)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .freeze (freeze),
            .inc    (inc[gi]),
            .ld     (ld[gi]),
            .ld_val (reg_wdata),
            .cnt    (cnt_flat[gi*CNT_W +: CNT_W])
         );
      end
   endgenerate

   chact_regs #(.W(CNT_W), .ADDR_W(ADDR_W), .N(N)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .cnt_flat (cnt_flat),
      .ld       (ld),
      .freeze   (freeze),
      .rdata    (reg_rdata)
   );

   // R4: all four counters stop on the same edge while frozen
   p_coherent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !reg_wr) |=> $stable(cnt_flat));
endmodule

// File: tb/test_chan_activity_counters.sv
`timescale 1ns/1ps
module test_chan_activity_counters;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        busy_i = 0, rx_i = 0, tx_i = 0;
   logic        reg_wr = 0;
   logic [2:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;

   int unsigned n_chk = 0, n_bad = 0;
   logic [31:0] m [4];
   logic        mfrz;

   always #4 clk = ~clk;

   chan_activity_counters i_chan_activity_counters (
      .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .rx_i(rx_i), .tx_i(tx_i),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] next_val(logic [31:0] v, logic en);
      return en ? v + 32'd1 : v;
   endfunction

   // one clock: inputs applied in the low phase, model updated at the edge
   task automatic step(logic b, logic r, logic t, logic w, logic [2:0] a, logic [31:0] d);
      logic [3:0] en;
      busy_i = b; rx_i = r; tx_i = t; reg_wr = w; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      en = {t, r, b, 1'b1};
      for (int i = 0; i < 4; i++) begin
         if (w && a == 3'(i + 1)) m[i] = d;
         else m[i] = next_val(m[i], en[i] && !mfrz);
      end
      if (w && a == 3'd0) mfrz = d[0];
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic read_all(string req);
      for (int i = 0; i < 4; i++) begin
         reg_addr = 3'(i + 1); #0.2;
         check(req, reg_rdata, m[i]);
      end
      reg_addr = 3'd0; #0.2;
      check({req, "/R7"}, reg_rdata, {31'd0, mfrz});
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] snap [4];
      void'($urandom(32'd7021));
      for (int i = 0; i < 4; i++) m[i] = '0;
      mfrz = 0;
      repeat (3) @(negedge clk);
      read_all("R1");
      rst_n = 1;
      @(negedge clk);
      for (int i = 0; i < 4; i++) m[i] = '0;
      reg_addr = 3'd1; #0.2;
      snap[0] = reg_rdata;
      m[0] = snap[0];   // one edge after release counted by the total counter
      check("R2", snap[0], 32'd1);
      // R2/R3: directed activity patterns
      step(1, 0, 0, 0, 3'd6, 0);
      step(0, 1, 0, 0, 3'd6, 0);
      step(0, 0, 1, 0, 3'd6, 0);
      step(1, 1, 1, 0, 3'd6, 0);
      read_all("R3");
      // R4: freeze, lag of one cycle, hold, resume
      step(1, 1, 1, 1, 3'd0, 32'd1);
      read_all("R4");
      repeat (5) step(1, 1, 1, 0, 3'd6, 0);
      read_all("R4");
      // R5/R4: freeze-read-clear-resume pass
      for (int i = 0; i < 4; i++) step(1, 0, 1, 1, 3'(i + 1), 32'd0);
      read_all("R5");
      step(0, 1, 1, 1, 3'd0, 32'd0);
      step(1, 1, 0, 0, 3'd6, 0);
      read_all("R4");
      // R5: write wins over increment
      step(1, 1, 1, 1, 3'd2, 32'h1234_5678);
      read_all("R5");
      // R6: wrap
      step(0, 0, 0, 1, 3'd1, 32'hFFFF_FFFE);
      step(0, 0, 0, 1, 3'd3, 32'hFFFF_FFFF);
      step(0, 1, 0, 0, 3'd6, 0);
      read_all("R6");
      // R8: unmapped reads zero, writes ignored
      for (int a = 5; a < 8; a++) begin
         step(0, 0, 0, 1, 3'(a), 32'hFFFF_FFFF);
         reg_addr = 3'(a); #0.2;
         check("R8", reg_rdata, 32'd0);
         read_all("R8");
      end
      // random mix against the model
      for (int k = 0; k < 400; k++) begin
         logic [31:0] rv;
         rv = $urandom;
         if (rv[7:5] == 3'd0)
            step(rv[0], rv[1], rv[2], 1, 3'($urandom_range(0, 7)),
                 rv[4] ? $urandom : 32'(rv[8]));
         else
            step(rv[0], rv[1], rv[2], 0, 3'd6, 0);
         if (k % 8 == 0) read_all("R3");
      end
      read_all("R2");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule